// File: doc/BRIEF.md
# Speculative Load Address Table

This block keeps track of loads that were moved ahead of older stores whose addresses were not yet known. When such an early load executes, it claims a slot that holds the load's destination register number and the granule of memory it read. Every store that executes afterwards presents its address. Any slot that covers the same granule is then cleared, because the early value may be stale.

Before the pipeline consumes an early-loaded value, it asks the table whether the slot for that destination register is still live. A hit means the value can be trusted. A miss means the pipeline has to reload the value or branch to recovery code. A flush input empties the whole table, for example on a context change or a pipeline squash.

The table is fully associative. It is searched by register number on the allocate and check paths, and by address granule on the store path. The reload and any data forwarding are handled outside this block.

Top module: `spec_ld_table`

## Requirements
- R1: After reset every slot is empty, `chk_rsp_vld_o` and `chk_hit_o` are low, and a check of any register returns a miss.
- R2: An allocation stores the register number and the address granule. A check of that register made in a later cycle returns a hit.
- R3: A check accepted on one clock edge produces `chk_rsp_vld_o` high for exactly one cycle, after that edge. The result reflects the table as it was before any allocation, store or flush in the same cycle.
- R4: A check of a register that has no live slot returns `chk_hit_o` = 0 while `chk_rsp_vld_o` = 1.
- R5: A store clears every live slot whose address bits [ADDR_W-1:3] equal the store's bits [ADDR_W-1:3]. Bits [2:0] take no part in the compare, and slots in other 8-byte granules are untouched.
- R6: An allocation for a register that already has a live slot overwrites that slot with the new address. No second slot is created, so the old address no longer clears it.
- R7: While a slot is empty, an allocation for a new register takes the empty slot with the lowest index. All ENTRIES distinct registers can be live at once.
- R8: When the table is full and the register is new, the slot under a replacement pointer is overwritten. The pointer starts at slot 0 after reset and moves forward by one slot, wrapping, on each such replacement.
- R9: When a store and an allocation to the same granule arrive in the same cycle, the allocated slot remains live. Other slots in that granule are still cleared.
- R10: A flush empties every slot in one cycle. It overrides an allocation presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Empty the whole table |
| alloc_vld_i | input | 1 | Early load allocates a slot |
| alloc_reg_i | input | REG_W | Destination register of the early load |
| alloc_addr_i | input | ADDR_W | Address read by the early load |
| snoop_vld_i | input | 1 | A store is executing |
| snoop_addr_i | input | ADDR_W | Store address |
| chk_vld_i | input | 1 | Check request |
| chk_reg_i | input | REG_W | Register to check |
| chk_rsp_vld_o | output | 1 | Check response strobe |
| chk_hit_o | output | 1 | 1 = slot live, 0 = reload or recover |

## Verification
Allocations, store clears and flushes change the table on the edge that accepts them, so their effect can first be seen by a check made one cycle later. That check's response appears on the edge after the check is accepted. The bench drives every input on the falling edge and samples the response on the next falling edge, which is one rising edge after the request. Checks that are presented in the same cycle as an allocation are expected to see the table as it was before that allocation.

// File: rtl/slt_pkg.sv
package slt_pkg;
   // Source of the slot chosen for an allocation
   typedef enum logic [1:0] {
      PICK_SAME_REG = 2'd0,
      PICK_FREE     = 2'd1,
      PICK_VICTIM   = 2'd2
   } pick_e;
endpackage

// File: rtl/slt_entry.sv
module slt_entry #(
   parameter int REG_W    = 7,
   parameter int ADDR_W   = 32,
   parameter int GRAN_LSB = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              we_i,
   input  logic [REG_W-1:0]  wr_reg_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic              snoop_vld_i,
   input  logic [ADDR_W-1:0] snoop_addr_i,
   input  logic [REG_W-1:0]  chk_reg_i,
   output logic              vld_o,
   output logic              chk_match_o,
   output logic              alloc_match_o
);
   localparam int TAG_W = ADDR_W - GRAN_LSB;

   logic             vld_q;
   logic [REG_W-1:0] reg_q;
   logic [TAG_W-1:0] tag_q;
   logic             snoop_hit;

   assign snoop_hit     = vld_q && snoop_vld_i && (tag_q == snoop_addr_i[ADDR_W-1:GRAN_LSB]);
   assign vld_o         = vld_q;
   assign chk_match_o   = vld_q && (reg_q == chk_reg_i);
   assign alloc_match_o = vld_q && (reg_q == wr_reg_i);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         reg_q <= '0;
         tag_q <= '0;
      end else if (clr_i) begin
         vld_q <= 1'b0;
      end else if (we_i) begin
         vld_q <= 1'b1;
         reg_q <= wr_reg_i;
         tag_q <= wr_addr_i[ADDR_W-1:GRAN_LSB];
      end else if (snoop_hit) begin
         vld_q <= 1'b0;
      end
   end

   // R2: a write leaves the slot live
   a_r2_write_sets_live: assert property (@(posedge clk) disable iff (!rst_n)
      we_i && !clr_i |=> vld_q);
   // R5: a matching store clears an untouched slot
   a_r5_snoop_clears: assert property (@(posedge clk) disable iff (!rst_n)
      snoop_hit && !we_i && !clr_i |=> !vld_q);
   // R9: write in the same granule as a store still leaves the slot live
   a_r9_write_over_snoop: assert property (@(posedge clk) disable iff (!rst_n)
      we_i && !clr_i && snoop_vld_i &&
      (wr_addr_i[ADDR_W-1:GRAN_LSB] == snoop_addr_i[ADDR_W-1:GRAN_LSB]) |=> vld_q);
   // R10: flush empties the slot
   a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> !vld_q);
endmodule

// File: rtl/slt_pick.sv
module slt_pick
   import slt_pkg::*;
#(
   parameter int ENTRIES = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_i,
   input  logic [ENTRIES-1:0] same_reg_i,
   input  logic [ENTRIES-1:0] vld_i,
   output logic [ENTRIES-1:0] we_o
);
   localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
   localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(ENTRIES - 1);

   logic [PTR_W-1:0]   ptr_q;
   logic [ENTRIES-1:0] free_vec, free_low, victim_vec, sel_vec;
   pick_e              src;

   assign free_vec   = ~vld_i;
   assign free_low   = free_vec & (~free_vec + ENTRIES'(1));
   assign victim_vec = ENTRIES'(1) << ptr_q;

   always_comb begin
      if (|same_reg_i)     src = PICK_SAME_REG;
      else if (|free_vec)  src = PICK_FREE;
      else                 src = PICK_VICTIM;
   end

   always_comb begin
      unique case (src)
         PICK_SAME_REG: sel_vec = same_reg_i;
         PICK_FREE:     sel_vec = free_low;
         default:       sel_vec = victim_vec;
      endcase
   end

   assign we_o = req_i ? sel_vec : '0;

   always_ff @(posedge clk) begin
      if (!rst_n)
         ptr_q <= '0;
      else if (req_i && src == PICK_VICTIM)
         ptr_q <= (ptr_q == PTR_LAST) ? '0 : ptr_q + PTR_W'(1);
   end

   // R6: an allocation writes exactly one slot
   a_r6_single_target: assert property (@(posedge clk) disable iff (!rst_n)
      req_i |-> $countones(we_o) == 1);
   // R8: the pointer moves only on a replacement
   a_r8_ptr_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_i && src == PICK_VICTIM) |=> $stable(ptr_q));
endmodule

// File: rtl/spec_ld_table.sv
module spec_ld_table #(
   parameter int ENTRIES  = 32,
   parameter int REG_W    = 7,
   parameter int ADDR_W   = 32,
   parameter int GRAN_LSB = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush_i,
   input  logic              alloc_vld_i,
   input  logic [REG_W-1:0]  alloc_reg_i,
   input  logic [ADDR_W-1:0] alloc_addr_i,
   input  logic              snoop_vld_i,
   input  logic [ADDR_W-1:0] snoop_addr_i,
   input  logic              chk_vld_i,
   input  logic [REG_W-1:0]  chk_reg_i,
   output logic              chk_rsp_vld_o,
   output logic              chk_hit_o
);
   if (ENTRIES < 2) begin : g_bad_entries
      $error("spec_ld_table: ENTRIES must be at least 2");
   end
   if (GRAN_LSB < 0 || GRAN_LSB >= ADDR_W) begin : g_bad_gran
      $error("spec_ld_table: GRAN_LSB must lie inside the address");
   end
   if (REG_W < 1) begin : g_bad_reg
      $error("spec_ld_table: REG_W must be positive");
   end

   logic [ENTRIES-1:0] vld_vec, chk_vec, same_vec, we_vec;
   logic               alloc_req;
   logic               rsp_vld_q, hit_q;

   assign alloc_req = alloc_vld_i && !flush_i;

   for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
      slt_entry #(.REG_W(REG_W), .ADDR_W(ADDR_W), .GRAN_LSB(GRAN_LSB)) u_slot (
         .clk          (clk),
         .rst_n        (rst_n),
         .clr_i        (flush_i),
         .we_i         (we_vec[i]),
         .wr_reg_i     (alloc_reg_i),
         .wr_addr_i    (alloc_addr_i),
         .snoop_vld_i  (snoop_vld_i),
         .snoop_addr_i (snoop_addr_i),
         .chk_reg_i    (chk_reg_i),
         .vld_o        (vld_vec[i]),
         .chk_match_o  (chk_vec[i]),
         .alloc_match_o(same_vec[i])
      );
   end

   slt_pick #(.ENTRIES(ENTRIES)) u_pick (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_i     (alloc_req),
      .same_reg_i(same_vec),
      .vld_i     (vld_vec),
      .we_o      (we_vec)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_vld_q <= 1'b0;
         hit_q     <= 1'b0;
      end else begin
         rsp_vld_q <= chk_vld_i;
         hit_q     <= chk_vld_i && (|chk_vec);
      end
   end

   assign chk_rsp_vld_o = rsp_vld_q;
   assign chk_hit_o     = hit_q;

   // R3: one response per accepted check, on the next edge
   a_r3_rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chk_vld_i |=> chk_rsp_vld_o);
   a_r3_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      !chk_vld_i |=> !chk_rsp_vld_o);
   // R4: a hit is only reported with a response strobe
   a_r4_hit_needs_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      chk_hit_o |-> chk_rsp_vld_o);
   // R6: a register never owns two live slots
   a_r6_no_dup_reg: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(same_vec));
   // R10: after a flush nothing is live
   a_r10_table_empty: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> vld_vec == '0);
endmodule

// File: tb/spec_ld_table_tb.sv
module spec_ld_table_tb;
   localparam int ENTRIES = 32;
   localparam int REG_W   = 7;
   localparam int ADDR_W  = 32;

   // vector: {op[1:0], reg[6:0], addr[31:0], exp}; op 0 alloc, 1 store, 2 check, 3 flush
   localparam int NV = 18;
   localparam logic [41:0] VEC [NV] = '{
      {2'd0, 7'd3,  32'h0000_1000, 1'b0},
      {2'd2, 7'd3,  32'h0,         1'b1},  // R2
      {2'd2, 7'd4,  32'h0,         1'b0},  // R4
      {2'd0, 7'd4,  32'h0000_1008, 1'b0},
      {2'd1, 7'd0,  32'h0000_1004, 1'b0},  // same granule as 0x1000
      {2'd2, 7'd3,  32'h0,         1'b0},  // R5 cleared
      {2'd2, 7'd4,  32'h0,         1'b1},  // R5 other granule kept
      {2'd0, 7'd4,  32'h0000_2000, 1'b0},  // R6 overwrite
      {2'd1, 7'd0,  32'h0000_1008, 1'b0},
      {2'd2, 7'd4,  32'h0,         1'b1},  // R6 old address no effect
      {2'd0, 7'd7,  32'h0000_2003, 1'b0},
      {2'd0, 7'd9,  32'h0000_3000, 1'b0},
      {2'd1, 7'd0,  32'h0000_2007, 1'b0},
      {2'd2, 7'd4,  32'h0,         1'b0},  // R5
      {2'd2, 7'd7,  32'h0,         1'b0},  // R5
      {2'd2, 7'd9,  32'h0,         1'b1},  // R5
      {2'd3, 7'd0,  32'h0,         1'b0},
      {2'd2, 7'd9,  32'h0,         1'b0}   // R10
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic flush_i = 1'b0;
   logic alloc_vld_i = 1'b0;
   logic [REG_W-1:0] alloc_reg_i = '0;
   logic [ADDR_W-1:0] alloc_addr_i = '0;
   logic snoop_vld_i = 1'b0;
   logic [ADDR_W-1:0] snoop_addr_i = '0;
   logic chk_vld_i = 1'b0;
   logic [REG_W-1:0] chk_reg_i = '0;
   logic chk_rsp_vld_o, chk_hit_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   spec_ld_table #(.ENTRIES(ENTRIES), .REG_W(REG_W), .ADDR_W(ADDR_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
      .alloc_vld_i(alloc_vld_i), .alloc_reg_i(alloc_reg_i), .alloc_addr_i(alloc_addr_i),
      .snoop_vld_i(snoop_vld_i), .snoop_addr_i(snoop_addr_i),
      .chk_vld_i(chk_vld_i), .chk_reg_i(chk_reg_i),
      .chk_rsp_vld_o(chk_rsp_vld_o), .chk_hit_o(chk_hit_o)
   );

   task automatic cmp(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   // drive one cycle of inputs at a falling edge, return at the next falling edge
   task automatic cyc(input logic av, input logic [REG_W-1:0] ar, input logic [ADDR_W-1:0] aa,
                      input logic sv, input logic [ADDR_W-1:0] sa,
                      input logic cv, input logic [REG_W-1:0] cr, input logic fl);
      alloc_vld_i = av; alloc_reg_i = ar; alloc_addr_i = aa;
      snoop_vld_i = sv; snoop_addr_i = sa;
      chk_vld_i = cv; chk_reg_i = cr; flush_i = fl;
      @(negedge clk);
      alloc_vld_i = 1'b0; snoop_vld_i = 1'b0; chk_vld_i = 1'b0; flush_i = 1'b0;
   endtask

   task automatic check_reg(input string req, input logic [REG_W-1:0] r, input logic exp);
      cyc(1'b0, '0, '0, 1'b0, '0, 1'b1, r, 1'b0);
      cmp({req, " rsp_vld"}, chk_rsp_vld_o, 1'b1);
      cmp({req, " hit"}, chk_hit_o, exp);
   endtask

   task automatic alloc(input logic [REG_W-1:0] r, input logic [ADDR_W-1:0] a);
      cyc(1'b1, r, a, 1'b0, '0, 1'b0, '0, 1'b0);
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      cmp("R1 rsp_vld", chk_rsp_vld_o, 1'b0);
      cmp("R1 hit", chk_hit_o, 1'b0);
      check_reg("R1", 7'd3, 1'b0);

      // vector table
      for (int i = 0; i < NV; i++) begin
         logic [1:0] op;
         logic [REG_W-1:0] r;
         logic [ADDR_W-1:0] a;
         logic e;
         {op, r, a, e} = VEC[i];
         case (op)
            2'd0: alloc(r, a);
            2'd1: cyc(1'b0, '0, '0, 1'b1, a, 1'b0, '0, 1'b0);
            2'd2: check_reg("R2/R4/R5/R6/R10 vector", r, e);
            default: cyc(1'b0, '0, '0, 1'b0, '0, 1'b0, '0, 1'b1);
         endcase
      end

      // R3: response pulse lasts one cycle
      cyc(1'b0, '0, '0, 1'b0, '0, 1'b0, '0, 1'b0);
      cmp("R3 no rsp without check", chk_rsp_vld_o, 1'b0);
      // R3: check in the same cycle as its allocation sees the old table
      cyc(1'b1, 7'd20, 32'h0000_0700, 1'b0, '0, 1'b1, 7'd20, 1'b0);
      cmp("R3 same-cycle rsp_vld", chk_rsp_vld_o, 1'b1);
      cmp("R3 same-cycle pre-update miss", chk_hit_o, 1'b0);
      check_reg("R3 next-cycle", 7'd20, 1'b1);

      // R7 / R8: fill then replace round robin
      cyc(1'b0, '0, '0, 1'b0, '0, 1'b0, '0, 1'b1);
      for (int k = 0; k < ENTRIES; k++) alloc(REG_W'(k), 32'h0000_4000 + 32'(k * 8));
      for (int k = 0; k < ENTRIES; k++) check_reg("R7 all live", REG_W'(k), 1'b1);
      alloc(7'd40, 32'h0000_8000);
      check_reg("R8 slot0 replaced", 7'd0, 1'b0);
      check_reg("R8 slot1 kept", 7'd1, 1'b1);
      check_reg("R8 new reg", 7'd40, 1'b1);
      alloc(7'd41, 32'h0000_8008);
      check_reg("R8 slot1 replaced", 7'd1, 1'b0);
      check_reg("R8 slot2 kept", 7'd2, 1'b1);
      // R7: a cleared slot is reused before any replacement
      cyc(1'b0, '0, '0, 1'b1, 32'h0000_4028, 1'b0, '0, 1'b0); // clears reg 5
      alloc(7'd50, 32'h0000_9000);
      check_reg("R7 free slot used", 7'd50, 1'b1);
      check_reg("R7 no replacement", 7'd2, 1'b1);

      // R9: store and allocation to the same granule
      cyc(1'b0, '0, '0, 1'b0, '0, 1'b0, '0, 1'b1);
      alloc(7'd10, 32'h0000_0500);
      cyc(1'b1, 7'd11, 32'h0000_0502, 1'b1, 32'h0000_0505, 1'b0, '0, 1'b0);
      check_reg("R9 other slot cleared", 7'd10, 1'b0);
      check_reg("R9 allocated slot live", 7'd11, 1'b1);

      // R10: flush overrides same-cycle allocation
      cyc(1'b1, 7'd12, 32'h0000_0600, 1'b0, '0, 1'b0, '0, 1'b1);
      check_reg("R10 alloc dropped", 7'd12, 1'b0);
      check_reg("R10 old slot gone", 7'd11, 1'b0);

      finish_run();
   end
endmodule